// File: doc/BRIEF.md
# Streaming Photon Event Centroider

This block sits behind an image sensor and turns a raster pixel stream into a stream of photon-event records. Pixels enter on a valid/ready handshake, qualified by frame-valid and line-valid levels. The block stores the four previous rows in on-chip line buffers. With the arriving pixel, these rows form a 5×5 window that moves across the image one accepted pixel at a time. Each window is judged around its centre pixel. The local background is the dimmest of the four window corners. A centre that is the strict maximum of the window and rises above that background is a photon event. The event is kept only if at least one neighbour is also above the background, so a lone bright pixel is rejected as a hot pixel.

For each event the block reports the following:
- the centre's column and row;
- the centre intensity;
- the spread between the brightest and dimmest corners, and a multiple-event flag set when that spread exceeds a programmable limit;
- for each axis, a direction bit, a numerator and a denominator.

The sub-pixel offset is numerator ÷ denominator. The block does not perform the division; a later stage resolves it.

Records leave on a valid/ready port. A record is held unchanged while `ev_ready` is low. A window whose record cannot be stored stalls the input by dropping `pix_ready`, so no event is lost. With `ev_ready` tied high, `ev_valid` is a one-cycle strobe per event.

Top module: `photon_centroider`

## Requirements
- R1: After reset `ev_valid` is 0 and `pix_ready` is 1.
- R2: A pixel is taken only on a cycle with `frame_valid`, `line_valid`, `pix_valid` and `pix_ready` all high; other cycles have no effect. Each taken pixel advances the column by one. The column returns to 0 and the row advances by one when `line_valid` falls after a non-empty line. Both column and row clear on a rising edge of `frame_valid`.
- R3: The window completed by the pixel at (column c, row r) is centred on (c−2, r−2), and the record's `ev_col`/`ev_row` carry that centre.
- R4: No record is produced for a centre closer than two pixels to any image edge.
- R5: Threshold = minimum of the four window corners. An event needs the centre strictly above every one of the other 24 window pixels and strictly above the threshold.
- R6: A candidate whose 24 neighbours are all at or below the threshold is dropped as a hot pixel.
- R7: `ev_spread` = largest corner − smallest corner (unsigned). `ev_multi` = 1 exactly when `ev_spread` > `multi_limit`.
- R8: With L/R the pixels left/right of centre: `ev_xsign` = 1 when R > L (offset toward higher column), `ev_xnum` = |R − L|, `ev_xden` = L + centre + R.
- R9: With T/B the pixels above/below centre: `ev_ysign` = 1 when B > T (offset toward higher row), `ev_ynum` = |B − T|, `ev_yden` = T + centre + B.
- R10: `ev_peak` is the centre pixel value.
- R11: While `ev_valid` is high and `ev_ready` low the record stays unchanged. Records come out in raster order of their centres, and none is dropped or repeated under any `ev_ready` pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| multi_limit | input | PIX_W | Corner-spread limit for the multiple-event flag |
| frame_valid | input | 1 | Frame qualifier level |
| line_valid | input | 1 | Line qualifier level |
| pix_valid | input | 1 | Pixel present |
| pix_ready | output | 1 | Block can take a pixel |
| pix_data | input | PIX_W | Pixel intensity |
| ev_valid | output | 1 | Event record present |
| ev_ready | input | 1 | Consumer takes the record |
| ev_col | output | clog2(LINE_W) | Centre column |
| ev_row | output | ROW_W | Centre row |
| ev_peak | output | PIX_W | Centre intensity |
| ev_spread | output | PIX_W | Max corner minus min corner |
| ev_multi | output | 1 | Multiple-event flag |
| ev_xsign | output | 1 | Horizontal direction bit |
| ev_xnum | output | PIX_W | Horizontal numerator |
| ev_xden | output | PIX_W+2 | Horizontal denominator |
| ev_ysign | output | 1 | Vertical direction bit |
| ev_ynum | output | PIX_W | Vertical numerator |
| ev_yden | output | PIX_W+2 | Vertical denominator |

## Verification
The checker assumes that no line carries more than LINE_W taken pixels and that `multi_limit` does not change during a frame. The bench drives lines of fixed width below that limit and changes the limit only between frames, after every pending record has drained. It also presents garbage pixels while `line_valid` is low. It inserts random input gaps and random `ev_ready` stalls so that the hold and no-loss properties are exercised under back-pressure, not only in free flow.

// File: rtl/pc_pkg.sv
package pc_pkg;
  // Window geometry is fixed by the algorithm; sizes of the image are parameters.
  localparam int WIN     = 5;
  localparam int HALF    = WIN / 2;
  localparam int LB_ROWS = WIN - 1;
endpackage

// File: rtl/pc_raster_track.sv
module pc_raster_track
  import pc_pkg::*;
#(
  parameter int COL_W = 6,
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic             line_valid,
  input  logic             take,
  output logic [COL_W-1:0] cur_col,
  output logic [ROW_W-1:0] cur_row
);
  logic             fv_q, lv_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             frame_start, line_end;

  assign frame_start = frame_valid & ~fv_q;
  assign line_end    = ~line_valid & lv_q;

  // A frame start overrides the stored position in the same cycle.
  assign cur_col = frame_start ? '0 : col_q;
  assign cur_row = frame_start ? '0 : row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fv_q  <= 1'b0;
      lv_q  <= 1'b0;
      col_q <= '0;
      row_q <= '0;
    end else begin
      fv_q <= frame_valid;
      lv_q <= line_valid;
      if (take) begin
        col_q <= cur_col + COL_W'(1);
        row_q <= cur_row;
      end else if (frame_start) begin
        col_q <= '0;
        row_q <= '0;
      end else if (line_end) begin
        col_q <= '0;
        if (col_q != '0) row_q <= row_q + ROW_W'(1);
      end
    end
  end
endmodule

// File: rtl/pc_line_window.sv
module pc_line_window
  import pc_pkg::*;
#(
  parameter int LINE_W = 64,
  parameter int PIX_W  = 8,
  parameter int COL_W  = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  take,
  input  logic [COL_W-1:0]                      col,
  input  logic [PIX_W-1:0]                      pix,
  output logic [WIN-1:0][WIN-1:0][PIX_W-1:0]    win
);
  localparam logic [COL_W:0] LINE_CNT = (COL_W+1)'(LINE_W);

  // Each column slot keeps the last LB_ROWS rows; index 0 is the newest.
  logic [LB_ROWS-1:0][PIX_W-1:0] lb [LINE_W];
  logic [LB_ROWS-1:0][PIX_W-1:0] rd;
  logic [WIN-1:0][PIX_W-1:0]     newcol;
  logic                          in_range;

  assign in_range = ({1'b0, col} < LINE_CNT);
  assign rd       = in_range ? lb[col] : '0;

  // Top of the window is the oldest row, bottom is the arriving pixel.
  generate
    for (genvar r = 0; r < LB_ROWS; r++) begin : g_col
      assign newcol[r] = rd[LB_ROWS-1-r];
    end
  endgenerate
  assign newcol[WIN-1] = pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINE_W; i++) lb[i] <= '0;
    end else if (take && in_range) begin
      lb[col] <= {rd[LB_ROWS-2:0], pix};
    end
  end

  generate
    for (genvar r = 0; r < WIN; r++) begin : g_row
      for (genvar c = 0; c < WIN; c++) begin : g_cell
        always_ff @(posedge clk) begin
          if (!rst_n)    win[r][c] <= '0;
          else if (take) begin
            if (c == WIN-1) win[r][c] <= newcol[r];
            else            win[r][c] <= win[r][c+1];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pc_event_eval.sv
module pc_event_eval
  import pc_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int DEN_W = PIX_W + 2
) (
  input  logic [WIN-1:0][WIN-1:0][PIX_W-1:0] win,
  input  logic [PIX_W-1:0]                   multi_limit,
  output logic                               is_event,
  output logic [PIX_W-1:0]                   peak,
  output logic [PIX_W-1:0]                   spread,
  output logic                               multi,
  output logic                               xsign,
  output logic [PIX_W-1:0]                   xnum,
  output logic [DEN_W-1:0]                   xden,
  output logic                               ysign,
  output logic [PIX_W-1:0]                   ynum,
  output logic [DEN_W-1:0]                   yden
);
  logic [PIX_W-1:0] k0, k1, k2, k3, lo01, lo23, hi01, hi23, thr, cmax;
  logic [PIX_W-1:0] lft, rgt, top, bot;
  logic             peak_wins, neighbour_lit;

  assign peak = win[HALF][HALF];
  assign k0   = win[0][0];
  assign k1   = win[0][WIN-1];
  assign k2   = win[WIN-1][0];
  assign k3   = win[WIN-1][WIN-1];

  assign lo01 = (k0 < k1) ? k0 : k1;
  assign lo23 = (k2 < k3) ? k2 : k3;
  assign hi01 = (k0 > k1) ? k0 : k1;
  assign hi23 = (k2 > k3) ? k2 : k3;
  assign thr  = (lo01 < lo23) ? lo01 : lo23;
  assign cmax = (hi01 > hi23) ? hi01 : hi23;

  always_comb begin
    peak_wins     = 1'b1;
    neighbour_lit = 1'b0;
    for (int r = 0; r < WIN; r++) begin
      for (int c = 0; c < WIN; c++) begin
        if (!(r == HALF && c == HALF)) begin
          peak_wins     = peak_wins & (peak > win[r][c]);
          neighbour_lit = neighbour_lit | (win[r][c] > thr);
        end
      end
    end
  end

  assign is_event = peak_wins & (peak > thr) & neighbour_lit;
  assign spread   = cmax - thr;
  assign multi    = spread > multi_limit;

  assign lft   = win[HALF][HALF-1];
  assign rgt   = win[HALF][HALF+1];
  assign top   = win[HALF-1][HALF];
  assign bot   = win[HALF+1][HALF];

  assign xsign = rgt > lft;
  assign xnum  = xsign ? (rgt - lft) : (lft - rgt);
  assign xden  = DEN_W'(lft) + DEN_W'(peak) + DEN_W'(rgt);
  assign ysign = bot > top;
  assign ynum  = ysign ? (bot - top) : (top - bot);
  assign yden  = DEN_W'(top) + DEN_W'(peak) + DEN_W'(bot);
endmodule

// File: rtl/photon_centroider.sv
module photon_centroider
  import pc_pkg::*;
#(
  parameter int LINE_W = 64,
  parameter int PIX_W  = 8,
  parameter int ROW_W  = 11,
  localparam int COL_W = $clog2(LINE_W),
  localparam int DEN_W = PIX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] multi_limit,
  input  logic             frame_valid,
  input  logic             line_valid,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  output logic             ev_valid,
  input  logic             ev_ready,
  output logic [COL_W-1:0] ev_col,
  output logic [ROW_W-1:0] ev_row,
  output logic [PIX_W-1:0] ev_peak,
  output logic [PIX_W-1:0] ev_spread,
  output logic             ev_multi,
  output logic             ev_xsign,
  output logic [PIX_W-1:0] ev_xnum,
  output logic [DEN_W-1:0] ev_xden,
  output logic             ev_ysign,
  output logic [PIX_W-1:0] ev_ynum,
  output logic [DEN_W-1:0] ev_yden
);
  localparam logic [COL_W-1:0] COL_EDGE = COL_W'(WIN-1);
  localparam logic [ROW_W-1:0] ROW_EDGE = ROW_W'(WIN-1);

  logic             take, out_free, win_new;
  logic [COL_W-1:0] cur_col, ctr_col;
  logic [ROW_W-1:0] cur_row, ctr_row;
  logic [WIN-1:0][WIN-1:0][PIX_W-1:0] win;

  logic             e_hit, e_multi, e_xs, e_ys;
  logic [PIX_W-1:0] e_peak, e_spread, e_xn, e_yn;
  logic [DEN_W-1:0] e_xd, e_yd;

  assign out_free  = ~ev_valid | ev_ready;
  assign pix_ready = ~win_new | out_free;
  assign take      = frame_valid & line_valid & pix_valid & pix_ready;

  pc_raster_track #(.COL_W(COL_W), .ROW_W(ROW_W)) u_track (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .line_valid(line_valid),
    .take(take), .cur_col(cur_col), .cur_row(cur_row)
  );

  pc_line_window #(.LINE_W(LINE_W), .PIX_W(PIX_W), .COL_W(COL_W)) u_window (
    .clk(clk), .rst_n(rst_n), .take(take), .col(cur_col), .pix(pix_data), .win(win)
  );

  pc_event_eval #(.PIX_W(PIX_W)) u_eval (
    .win(win), .multi_limit(multi_limit), .is_event(e_hit), .peak(e_peak),
    .spread(e_spread), .multi(e_multi), .xsign(e_xs), .xnum(e_xn), .xden(e_xd),
    .ysign(e_ys), .ynum(e_yn), .yden(e_yd)
  );

  // Window stage: one pending window, replaced only when it is consumed.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_new <= 1'b0;
      ctr_col <= '0;
      ctr_row <= '0;
    end else if (take) begin
      win_new <= (cur_col >= COL_EDGE) && (cur_row >= ROW_EDGE);
      ctr_col <= cur_col - COL_W'(HALF);
      ctr_row <= cur_row - ROW_W'(HALF);
    end else if (out_free) begin
      win_new <= 1'b0;
    end
  end

  // Record stage.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid  <= 1'b0;
      ev_col    <= '0;
      ev_row    <= '0;
      ev_peak   <= '0;
      ev_spread <= '0;
      ev_multi  <= 1'b0;
      ev_xsign  <= 1'b0;
      ev_xnum   <= '0;
      ev_xden   <= '0;
      ev_ysign  <= 1'b0;
      ev_ynum   <= '0;
      ev_yden   <= '0;
    end else if (out_free) begin
      ev_valid <= win_new & e_hit;
      if (win_new & e_hit) begin
        ev_col    <= ctr_col;
        ev_row    <= ctr_row;
        ev_peak   <= e_peak;
        ev_spread <= e_spread;
        ev_multi  <= e_multi;
        ev_xsign  <= e_xs;
        ev_xnum   <= e_xn;
        ev_xden   <= e_xd;
        ev_ysign  <= e_ys;
        ev_ynum   <= e_yn;
        ev_yden   <= e_yd;
      end
    end
  end
endmodule

// File: rtl/pc_centroider_chk.sv
module pc_centroider_chk #(
  parameter int PIX_W = 8,
  parameter int COL_W = 6,
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_ready,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [COL_W-1:0] ev_col,
  input logic [ROW_W-1:0] ev_row,
  input logic [PIX_W-1:0] ev_peak,
  input logic [PIX_W-1:0] ev_spread,
  input logic             ev_multi,
  input logic [PIX_W-1:0] ev_xnum,
  input logic [PIX_W+1:0] ev_xden,
  input logic [PIX_W-1:0] ev_ynum,
  input logic [PIX_W+1:0] ev_yden
);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_col) && $stable(ev_row) &&
      $stable(ev_peak) && $stable(ev_spread) && $stable(ev_xnum) && $stable(ev_ynum));

  a_r11_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> pix_ready);

  a_r4_border: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_col >= COL_W'(2)) && (ev_row >= ROW_W'(2)));

  a_r5_peak_lit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_peak != '0);

  a_r7_multi_spread: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_multi |-> ev_spread != '0);

  a_r8_xden: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> {2'b00, ev_xnum} <= ev_xden);

  a_r9_yden: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> {2'b00, ev_ynum} <= ev_yden);
endmodule

bind photon_centroider pc_centroider_chk #(.PIX_W(PIX_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_col(ev_col), .ev_row(ev_row), .ev_peak(ev_peak), .ev_spread(ev_spread),
  .ev_multi(ev_multi), .ev_xnum(ev_xnum), .ev_xden(ev_xden), .ev_ynum(ev_ynum),
  .ev_yden(ev_yden)
);

// File: tb/photon_centroider_bench.sv
module photon_centroider_bench;
  localparam int LW = 16;
  localparam int RW = 6;
  localparam int W  = 12;
  localparam int H  = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] multi_limit = 8'd0;
  logic       frame_valid = 1'b0, line_valid = 1'b0, pix_valid = 1'b0;
  logic [7:0] pix_data = 8'd0;
  logic       ev_ready = 1'b1;
  logic       pix_ready, ev_valid, ev_multi, ev_xsign, ev_ysign;
  logic [3:0] ev_col;
  logic [RW-1:0] ev_row;
  logic [7:0] ev_peak, ev_spread, ev_xnum, ev_ynum;
  logic [9:0] ev_xden, ev_yden;

  always #5 clk = ~clk;

  photon_centroider #(.LINE_W(LW), .PIX_W(8), .ROW_W(RW)) u_photon_centroider (
    .clk(clk), .rst_n(rst_n), .multi_limit(multi_limit), .frame_valid(frame_valid),
    .line_valid(line_valid), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_col(ev_col),
    .ev_row(ev_row), .ev_peak(ev_peak), .ev_spread(ev_spread), .ev_multi(ev_multi),
    .ev_xsign(ev_xsign), .ev_xnum(ev_xnum), .ev_xden(ev_xden), .ev_ysign(ev_ysign),
    .ev_ynum(ev_ynum), .ev_yden(ev_yden)
  );

  typedef struct {
    int col, row, pk, sp, mu, xs, xn, xd, ys, yn, yd;
  } rec_t;

  int   total = 0, bad = 0, got_frame = 0;
  bit   done = 1'b0, stall_mode = 1'b0;
  int unsigned seed = 32'd7, rseed = 32'd99;
  int   img [H][W];
  rec_t exp_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 8);
  endfunction

  // Expected records, straight from the requirements.
  function automatic void model(input int lim);
    for (int r = 2; r <= H - 3; r++) begin
      for (int c = 2; c <= W - 3; c++) begin
        int k[4];
        int thr, mx, ctr;
        bit wins, lit;
        rec_t e;
        k[0] = img[r-2][c-2]; k[1] = img[r-2][c+2];
        k[2] = img[r+2][c-2]; k[3] = img[r+2][c+2];
        thr = k[0]; mx = k[0];
        for (int i = 1; i < 4; i++) begin
          if (k[i] < thr) thr = k[i];
          if (k[i] > mx) mx = k[i];
        end
        ctr = img[r][c];
        wins = 1'b1; lit = 1'b0;
        for (int dr = -2; dr <= 2; dr++)
          for (int dc = -2; dc <= 2; dc++)
            if (dr != 0 || dc != 0) begin
              if (!(ctr > img[r+dr][c+dc])) wins = 1'b0;
              if (img[r+dr][c+dc] > thr) lit = 1'b1;
            end
        if (wins && ctr > thr && lit) begin
          e.col = c; e.row = r; e.pk = ctr; e.sp = mx - thr;
          e.mu = (mx - thr > lim) ? 1 : 0;
          e.xs = (img[r][c+1] > img[r][c-1]) ? 1 : 0;
          e.xn = e.xs ? img[r][c+1] - img[r][c-1] : img[r][c-1] - img[r][c+1];
          e.xd = img[r][c-1] + ctr + img[r][c+1];
          e.ys = (img[r+1][c] > img[r-1][c]) ? 1 : 0;
          e.yn = e.ys ? img[r+1][c] - img[r-1][c] : img[r-1][c] - img[r+1][c];
          e.yd = img[r-1][c] + ctr + img[r+1][c];
          exp_q.push_back(e);
        end
      end
    end
  endfunction

  task automatic consume();
    rec_t e;
    got_frame++;
    if (exp_q.size() == 0) begin
      check(1'b0, "R5 unexpected record", int'(ev_col), -1);
      return;
    end
    e = exp_q.pop_front();
    check(int'(ev_col) == e.col, "R3 col", int'(ev_col), e.col);
    check(int'(ev_row) == e.row, "R3 row", int'(ev_row), e.row);
    check(int'(ev_peak) == e.pk, "R10 peak", int'(ev_peak), e.pk);
    check(int'(ev_spread) == e.sp, "R7 spread", int'(ev_spread), e.sp);
    check(int'(ev_multi) == e.mu, "R7 multi", int'(ev_multi), e.mu);
    check(int'(ev_xsign) == e.xs && int'(ev_xnum) == e.xn, "R8 xsign/xnum",
          int'(ev_xnum) + 1000 * int'(ev_xsign), e.xn + 1000 * e.xs);
    check(int'(ev_xden) == e.xd, "R8 xden", int'(ev_xden), e.xd);
    check(int'(ev_ysign) == e.ys && int'(ev_ynum) == e.yn, "R9 ysign/ynum",
          int'(ev_ynum) + 1000 * int'(ev_ysign), e.yn + 1000 * e.ys);
    check(int'(ev_yden) == e.yd, "R9 yden", int'(ev_yden), e.yd);
  endtask

  // One cycle: drive at the falling edge, observe handshakes before the rising edge.
  task automatic tick(input bit fv, input bit lv, input bit pv, input int d, output bit took);
    @(negedge clk);
    frame_valid = fv; line_valid = lv; pix_valid = pv; pix_data = 8'(d);
    rseed = rseed * 32'd69069 + 32'd1;
    ev_ready = stall_mode ? rseed[20] : 1'b1;
    #1;
    took = fv && lv && pv && pix_ready;
    if (ev_valid && ev_ready) consume();
  endtask

  task automatic send_frame(input int lim, input string tag);
    bit t;
    int want;
    multi_limit = 8'(lim);
    exp_q.delete();
    model(lim);
    want = exp_q.size();
    got_frame = 0;
    tick(1, 0, 0, 0, t);
    tick(1, 0, 1, 8'hEE, t);      // pixel with line low: ignored (R2)
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        do begin
          if (stall_mode && rnd() % 4 == 0) tick(1, 1, 0, 8'hFF, t);
          tick(1, 1, 1, img[r][c], t);
        end while (!t);
      end
      tick(1, 0, 1, 8'hFF, t);
      tick(1, 0, 0, 0, t);
    end
    tick(0, 0, 1, 8'hFF, t);
    stall_mode = 1'b0;
    for (int i = 0; i < 8; i++) tick(0, 0, 0, 0, t);
    check(got_frame == want, tag, got_frame, want);
  endtask

  function automatic void fill_bg(input int v);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r][c] = v;
  endfunction

  initial begin
    bit t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(ev_valid == 1'b0, "R1 ev_valid after reset", int'(ev_valid), 0);
    check(pix_ready == 1'b1, "R1 pix_ready after reset", int'(pix_ready), 1);

    // Flat field: centre never above the corner threshold.
    fill_bg(3);
    send_frame(0, "R5 flat frame record count");

    // One real event, one hot pixel, one event too close to the left edge.
    fill_bg(2);
    img[4][5] = 200; img[4][4] = 90; img[4][6] = 120; img[3][5] = 150; img[5][5] = 60;
    img[3][4] = 40; img[3][6] = 40; img[5][4] = 40; img[5][6] = 40;
    img[6][9] = 230;
    img[4][1] = 250; img[4][0] = 100; img[4][2] = 100;
    send_frame(255, "R6 R4 directed record count");

    // Corner gradient: spread 16, limit below and exactly at it.
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) img[r][c] = 4 * c;
    img[4][6] = 250;
    send_frame(10, "R7 spread above limit count");
    send_frame(16, "R7 spread equal limit count");

    // Random sparse frames with input gaps and output stalls.
    for (int f = 0; f < 6; f++) begin
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) begin
          int v;
          v = rnd();
          img[r][c] = (v % 9 == 0) ? 64 + (v >> 4) % 192 : (v >> 3) % 8;
        end
      stall_mode = 1'b1;
      send_frame((f * 53) % 256, "R11 R2 random frame record count");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule